// File: doc/BRIEF.md
# Reference-Matrix Least-Recently-Used Tracker

This block keeps the recency order of the lines in one set of a set-associative cache. The order is held as a square status matrix. Logical bit (r,c) is one when line r was used more recently than line c. Only the cells above the diagonal are stored, so N lines cost N(N-1)/2 flip-flops. A cell below the diagonal is read as the complement of its mirror cell above it.

Each access is reported with a strobe and the index of the line that was used. On that access the row of the line is set to ones and its column is cleared to zeros, which makes the line the most recent of all. The line whose row is all zeros and whose column is all ones is the least recently used. The block reports its index every cycle, so the cache can evict it when a miss finds the set full. The number of lines is a parameter and may be from 2 to 8.

There are no enumerated states. The stored triangle is the only state, and it is reloaded from its next value on every accepted strobe. The two events that change it are named in the requirements: reset, and an access.

Top module: `lru_refmatrix_tracker`

## Requirements
- R1: After reset, the stored cells are all ones and the victim is line NUM_LINES-1 (line 3 for the default of 4). If the victim is touched each time, the victims come out in the order NUM_LINES-1, NUM_LINES-2, …, 0, and then NUM_LINES-1 again.
- R2: In the cycle after an access to line i, the victim is not i.
- R3: The victim is always the line whose last access is the oldest. Lines not accessed since reset rank by the reset order: a higher index is older. An access to a line other than the victim leaves the victim unchanged.
- R4: `victim_idx_o` is the binary index (0 to NUM_LINES-1) of exactly one line. It is taken combinationally from the stored state.
- R5: During a cycle in which `touch_i` is high, `victim_idx_o` still shows the order before that access. The new order appears after the next rising clock edge.
- R6: With `touch_i` low the order is held and `victim_idx_o` does not change.
- R7: Repeated accesses to the same line leave the relative order of all other lines unchanged.
- R8: A reset asserted in the middle of operation discards the current order and brings back the order of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_i | input | 1 | Access strobe: a line of the set was used this cycle |
| touch_idx_i | input | $clog2(NUM_LINES) | Index of the line that was used |
| victim_idx_o | output | $clog2(NUM_LINES) | Index of the least recently used line |

## Verification
The assertions assume that `touch_idx_i` is below NUM_LINES whenever `touch_i` is high, and that the strobe is a clean single-cycle level sampled at the rising edge. The bench drives every access on the falling edge and only uses indexes 0 to NUM_LINES-1. These come from sweeps, from repeats of the victim and of a single line, and from a small shift-register sequence reduced modulo the line count. That keeps every stimulus inside those assumptions, while idle gaps and a mid-run reset still cover the hold and restart behaviour.

// File: rtl/lru_rm_pkg.sv
package lru_rm_pkg;

    // Position of upper-triangle cell (r,c), r<c, in the packed stored vector.
    // Row r holds the n-1-r cells that lie to the right of the diagonal.
    function automatic int tri_pos(input int n, input int r, input int c);
        return r * n - (r * (r + 1)) / 2 + (c - r - 1);
    endfunction

    function automatic int tri_size(input int n);
        return (n * (n - 1)) / 2;
    endfunction

endpackage

// File: rtl/lru_rm_store.sv
module lru_rm_store
    import lru_rm_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = $clog2(NUM_LINES),
    parameter int CELLS     = tri_size(NUM_LINES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             touch_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    output logic [CELLS-1:0] cells_q_o
);

    logic [CELLS-1:0] cells_q;
    logic [CELLS-1:0] cells_d;

    // Cell (r,c) with r<c: an access to r sets its row, so the cell becomes 1.
    // An access to c clears its column, so the cell becomes 0. Only one index
    // is presented per cycle, so the two updates never disagree on a cell.
    for (genvar r = 0; r < NUM_LINES; r++) begin : g_row
        for (genvar c = r + 1; c < NUM_LINES; c++) begin : g_col
            localparam int              POS    = tri_pos(NUM_LINES, r, c);
            localparam logic [IDX_W-1:0] ROW_ID = IDX_W'(r);
            localparam logic [IDX_W-1:0] COL_ID = IDX_W'(c);
            assign cells_d[POS] = (touch_i && touch_idx_i == ROW_ID) ? 1'b1 :
                                  (touch_i && touch_idx_i == COL_ID) ? 1'b0 :
                                  cells_q[POS];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cells_q <= '1;
        end else begin
            cells_q <= cells_d;
        end
    end

    assign cells_q_o = cells_q;

endmodule

// File: rtl/lru_rm_matrix.sv
module lru_rm_matrix
    import lru_rm_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int CELLS     = tri_size(NUM_LINES)
) (
    input  logic [CELLS-1:0]     cells_i,
    output logic [NUM_LINES-1:0] lru_onehot_o
);

    // Full logical matrix: mat[r][c]=1 means r is newer than c.
    logic [NUM_LINES-1:0][NUM_LINES-1:0] mat;
    // colv[l][r] collects column l, with the diagonal forced to 1.
    logic [NUM_LINES-1:0][NUM_LINES-1:0] colv;

    for (genvar r = 0; r < NUM_LINES; r++) begin : g_r
        for (genvar c = 0; c < NUM_LINES; c++) begin : g_c
            if (r < c) begin : g_upper
                assign mat[r][c] = cells_i[tri_pos(NUM_LINES, r, c)];
            end else if (r > c) begin : g_lower
                assign mat[r][c] = ~cells_i[tri_pos(NUM_LINES, c, r)];
            end else begin : g_diag
                assign mat[r][c] = 1'b0;
            end
            assign colv[c][r] = (r == c) ? 1'b1 : mat[r][c];
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign lru_onehot_o[l] = ~|mat[l] & (&colv[l]);
    end

endmodule

// File: rtl/lru_rm_encode.sv
module lru_rm_encode #(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] onehot_i,
    output logic [IDX_W-1:0]     index_o
);

    always_comb begin
        index_o = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (onehot_i[k]) begin
                index_o = index_o | IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/lru_refmatrix_tracker.sv
module lru_refmatrix_tracker
    import lru_rm_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int CELLS    = tri_size(NUM_LINES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             touch_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    output logic [IDX_W-1:0] victim_idx_o
);

    logic [CELLS-1:0]     cells_q;
    logic [NUM_LINES-1:0] lru_onehot;

    lru_rm_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .CELLS     (CELLS)
    ) store_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .touch_i     (touch_i),
        .touch_idx_i (touch_idx_i),
        .cells_q_o   (cells_q)
    );

    lru_rm_matrix #(
        .NUM_LINES (NUM_LINES),
        .CELLS     (CELLS)
    ) matrix_i (
        .cells_i      (cells_q),
        .lru_onehot_o (lru_onehot)
    );

    lru_rm_encode #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) encode_i (
        .onehot_i (lru_onehot),
        .index_o  (victim_idx_o)
    );

endmodule

// File: rtl/lru_rm_checker.sv
module lru_rm_checker #(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 touch_i,
    input logic [IDX_W-1:0]     touch_idx_i,
    input logic [IDX_W-1:0]     victim_idx_o,
    input logic [NUM_LINES-1:0] lru_onehot
);

    // R4: exactly one line qualifies as least recently used
    assert_single_victim_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(lru_onehot) == 1);

    // R4: the reported index names an existing line
    assert_victim_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(victim_idx_o) < NUM_LINES);

    // R2: a just-used line is never the next victim
    assert_touched_not_victim_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        touch_i |=> victim_idx_o != $past(touch_idx_i));

    // R6: no access, no change
    assert_idle_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !touch_i |=> $stable(victim_idx_o));

    // R3: using a line that is not the victim keeps the victim
    assert_other_touch_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (touch_i && touch_idx_i != victim_idx_o) |=> $stable(victim_idx_o));

endmodule

bind lru_refmatrix_tracker lru_rm_checker #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (touch_i),
    .touch_idx_i  (touch_idx_i),
    .victim_idx_o (victim_idx_o),
    .lru_onehot   (lru_onehot)
);

// File: tb/lru_refmatrix_tracker_tb_top.sv
`timescale 1ns/1ps
module lru_refmatrix_tracker_tb_top;

    localparam int N     = 4;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             touch = 1'b0;
    logic [IDX_W-1:0] touch_idx = '0;
    logic [IDX_W-1:0] victim;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // reference order: order_q[0] is the oldest line
    int    order_q[$];
    // scoreboard
    int    exp_q[$];
    int    idx_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    lru_refmatrix_tracker #(.NUM_LINES(N)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .touch_i      (touch),
        .touch_idx_i  (touch_idx),
        .victim_idx_o (victim)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: victim actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        order_q.delete();
        for (int i = N - 1; i >= 0; i--) order_q.push_back(i);
    endtask

    task automatic model_touch(input int idx);
        for (int k = 0; k < order_q.size(); k++) begin
            if (order_q[k] == idx) begin
                order_q.delete(k);
                break;
            end
        end
        order_q.push_back(idx);
    endtask

    // driver: one access per falling edge, expectation pushed for the monitor
    task automatic do_touch(input int idx, input string tag);
        @(negedge clk);
        touch     = 1'b1;
        touch_idx = IDX_W'(idx);
        #1;
        check("R5 pre-update view", int'(victim), order_q[0]);
        model_touch(idx);
        exp_q.push_back(order_q[0]);
        idx_q.push_back(idx);
        tag_q.push_back(tag);
    endtask

    task automatic do_idle(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            touch = 1'b0;
            exp_q.push_back(order_q[0]);
            idx_q.push_back(-1);
            tag_q.push_back("R6 idle hold");
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        touch = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        #1;
        check(tag, int'(victim), N - 1);
    endtask

    // monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                int    e;
                int    i;
                string t;
                e = exp_q.pop_front();
                i = idx_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(victim), e);
                if (int'(victim) >= N) check("R4 range", int'(victim), 0);
                if (i >= 0) begin
                    n_checks++;
                    if (int'(victim) == i) begin
                        n_fails++;
                        $display("FAIL R2: victim actual %0d expected not %0d", victim, i);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset victim", int'(victim), N - 1);

        // R1: evicting the victim each time walks the reset order
        for (int k = 0; k < N + 1; k++) do_touch(order_q[0], "R1 reset order walk");

        // R3: sweep in both directions
        for (int k = 0; k < N; k++) do_touch(k, "R3 ascending sweep");
        for (int k = N - 1; k >= 0; k--) do_touch(k, "R3 descending sweep");

        // R6: idle gap
        do_idle(4);

        // R7: hammer one line
        for (int k = 0; k < 5; k++) do_touch(2, "R7 repeated line");
        do_touch(order_q[0], "R7 order after repeats");
        do_touch(order_q[0], "R7 order after repeats");

        // R3: pseudo random accesses
        lfsr = 8'h5A;
        for (int k = 0; k < 60; k++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hFF;
            do_touch(lfsr % N, "R3 mixed accesses");
            if (k % 9 == 0) do_idle(1);
        end
        do_idle(2);

        // R8: reset in the middle of operation
        do_reset("R8 mid-run reset");
        for (int k = 0; k < N; k++) do_touch(order_q[0], "R8 order after reset");
        do_idle(2);

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule